// File: doc/BRIEF.md
# Overwrite-Oldest Byte Ring Buffer

This block is a circular byte store that accepts a byte on every write and never pushes back on the producer. While free slots remain, a write appends the byte and raises the occupancy by one. Once all slots are taken, a write still goes in. It takes the slot of the oldest byte, so the stored history is always the most recent `DEPTH` bytes. A one-cycle `overwrite` pulse marks each such replacement.

A consumer pops bytes in arrival order through a request input. The popped byte appears on `rd_byte` one cycle after the request and stays there until the next request. A pop from an empty buffer returns the sentinel value 0xFF and leaves the buffer untouched. A synchronous `flush` input empties the buffer. The `level` output reports the occupancy and is wide enough to hold the full depth. The depth defaults to 256 entries and need not be a power of two.

Top module: `ring_buffer_ovw`

## Requirements
- R1: After reset, `level` is 0, `rd_byte` is 0xFF and `overwrite` is 0.
- R2: A write while `level` is below DEPTH stores `wr_byte` and raises `level` by one on the following cycle.
- R3: A read request while `level` is non-zero puts the oldest stored byte on `rd_byte` in the cycle after the request and lowers `level` by one. Bytes leave in the order they arrived.
- R4: A read request while `level` is 0, with no write in the same cycle, sets `rd_byte` to 0xFF and leaves `level` at 0 and the stored contents unchanged.
- R5: A write while `level` equals DEPTH, with no read in the same cycle, keeps `level` at DEPTH and discards the oldest byte, so the next read returns the byte that was second oldest.
- R6: `overwrite` is high for exactly the one cycle after a write that lands on a full buffer without a read in the same cycle, and it is low at all other times.
- R7: A read and a write in the same cycle while `level` is between 1 and DEPTH-1 leave `level` unchanged. The read returns the byte that was oldest before that cycle.
- R8: A read and a write in the same cycle while full keep `level` at DEPTH, return the oldest byte and raise no `overwrite` pulse.
- R9: A read and a write in the same cycle while empty return 0xFF and leave `level` at 1, holding the written byte.
- R10: `flush` sets `level` to 0 on the next cycle and takes priority over a write or read in the same cycle. Any such write is dropped, any such read is ignored, and `rd_byte` keeps its value.
- R11: The read and write positions wrap modulo DEPTH, so arrival order is preserved across any number of passes around the storage.
- R12: While no read is requested, `rd_byte` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| flush | input | 1 | Synchronous clear of contents and positions |
| wr_valid | input | 1 | Write strobe, one byte per cycle |
| wr_byte | input | DATA_W | Byte to store |
| rd_req | input | 1 | Read request, one byte per cycle |
| rd_byte | output | DATA_W | Byte popped by the last request, or 0xFF after a pop from empty |
| level | output | $clog2(DEPTH+1) | Number of bytes held |
| overwrite | output | 1 | One-cycle pulse after a write that replaced the oldest byte |

## Verification
The assertions assume that `flush`, `wr_valid` and `rd_req` are defined (never X) on every rising edge once the internal reset has been released. They also assume that no stimulus arrives until that release, which happens two clock edges after `rst_n` rises. The bench meets both assumptions. It holds all inputs low through reset, waits several cycles after releasing `rst_n`, and drives every input on the falling edge, so each value is stable well before the edge that samples it.

// File: rtl/ovr_ring_pkg.sv
package ovr_ring_pkg;

  // Classification of the work done in one cycle by the occupancy logic.
  typedef enum logic [2:0] {
    RB_HOLD   = 3'd0,
    RB_APPEND = 3'd1,
    RB_REPLACE = 3'd2,
    RB_POP    = 3'd3,
    RB_SWAP   = 3'd4,
    RB_CLEAR  = 3'd5
  } rb_action_e;

  // Value returned by a pop from an empty store.
  localparam logic [7:0] RB_SENTINEL = 8'hFF;

endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/ring_index.sv
module ring_index #(
  parameter int DEPTH = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  // Next-state: clear wins, otherwise step with wrap at the last slot.
  always_comb begin
    idx_en = clr | adv;
    if (clr) begin
      idx_d = '0;
    end else if (idx_q == LAST_IDX) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

  // R11: the position never leaves the storage range.
  assert_idx_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  // R11: an advance from the last slot wraps to slot zero.
  assert_idx_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && idx_q == LAST_IDX) |=> (idx_q == '0));

endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ovr_ring_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_valid,
  input  logic             rd_req,
  output logic [CNT_W-1:0] level,
  output logic             store_en,
  output logic             wr_step,
  output logic             rd_step,
  output logic             clear,
  output logic             rd_capture,
  output logic             rd_sentinel,
  output logic             overwrite
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] level_d;
  logic             level_en;
  logic             ovw_q;
  logic             ovw_d;
  logic             is_empty;
  logic             is_full;
  logic             wr_go;
  logic             rd_go;
  rb_action_e       action;

  assign is_empty = (level_q == '0);
  assign is_full  = (level_q == FULL_LVL);
  assign wr_go    = wr_valid & ~flush;
  assign rd_go    = rd_req & ~flush;

  // Decide what this cycle does to the occupancy.
  always_comb begin
    if (flush) begin
      action = RB_CLEAR;
    end else if (wr_go && rd_go) begin
      action = is_empty ? RB_APPEND : RB_SWAP;
    end else if (wr_go) begin
      action = is_full ? RB_REPLACE : RB_APPEND;
    end else if (rd_go && !is_empty) begin
      action = RB_POP;
    end else begin
      action = RB_HOLD;
    end
  end

  // Next-state and strobes derived from the action.
  always_comb begin
    level_d     = level_q;
    level_en    = 1'b0;
    store_en    = 1'b0;
    wr_step     = 1'b0;
    rd_step     = 1'b0;
    clear       = 1'b0;
    ovw_d       = 1'b0;
    rd_capture  = rd_go;
    rd_sentinel = rd_go & is_empty;
    unique case (action)
      RB_CLEAR: begin
        clear    = 1'b1;
        level_d  = '0;
        level_en = 1'b1;
      end
      RB_APPEND: begin
        store_en = 1'b1;
        wr_step  = 1'b1;
        level_d  = level_q + CNT_W'(1);
        level_en = 1'b1;
      end
      RB_REPLACE: begin
        store_en = 1'b1;
        wr_step  = 1'b1;
        rd_step  = 1'b1;
        ovw_d    = 1'b1;
      end
      RB_SWAP: begin
        store_en = 1'b1;
        wr_step  = 1'b1;
        rd_step  = 1'b1;
      end
      RB_POP: begin
        rd_step  = 1'b1;
        level_d  = level_q - CNT_W'(1);
        level_en = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovw_q <= 1'b0;
    end else begin
      ovw_q <= ovw_d;
    end
  end

  assign level     = level_q;
  assign overwrite = ovw_q;

  // R5: occupancy never exceeds the depth.
  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= FULL_LVL);

  // R5: a write to a full store keeps it full.
  assert_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !flush && is_full) |=> (level_q == FULL_LVL));

  // R2: a lone write below the depth adds one.
  assert_append_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !rd_req && !flush && !is_full) |=> (level_q == $past(level_q) + CNT_W'(1)));

  // R3: a lone read from a non-empty store removes one.
  assert_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_valid && !flush && !is_empty) |=> (level_q == $past(level_q) - CNT_W'(1)));

  // R4: a lone read from an empty store leaves it empty.
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_valid && !flush && is_empty) |=> (level_q == '0));

  // R6: the pulse follows only a replacing write.
  assert_ovw_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_q |-> $past(wr_valid && !rd_req && !flush && is_full));

  // R7: a read and write together in the middle range keep the occupancy.
  assert_balanced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_req && !flush && !is_empty && !is_full) |=> $stable(level_q));

  // R8: a read and write together on a full store raise no pulse.
  assert_full_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_req && !flush && is_full) |=> (!ovw_q && level_q == FULL_LVL));

  // R9: a read and write together on an empty store leave one byte.
  assert_empty_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && rd_req && !flush && is_empty) |=> (level_q == CNT_W'(1)));

  // R10: flush empties the store on the next cycle.
  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level_q == '0 && !ovw_q));

endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int         DEPTH    = 256,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] SENTINEL = 8'hFF,
  localparam int        IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_capture,
  input  logic              rd_sentinel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] EMPTY_WORD = DATA_W'(SENTINEL);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_d;

  // Storage has no reset; contents are only meaningful below the level.
  always_ff @(posedge clk) begin
    if (store_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  // The slot is read before this edge's write lands in it.
  always_comb begin
    rd_d = rd_sentinel ? EMPTY_WORD : mem_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= EMPTY_WORD;
    end else if (rd_capture) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  // R12: without a capture the output register holds.
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rd_q));

  // R4: a sentinel capture yields the sentinel word.
  assert_sentinel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_capture && rd_sentinel) |=> (rd_q == EMPTY_WORD));

endmodule

// File: rtl/ring_buffer_ovw.sv
module ring_buffer_ovw
  import ovr_ring_pkg::*;
#(
  parameter int  DEPTH  = 256,
  parameter int  DATA_W = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_byte,
  output logic [CNT_W-1:0]  level,
  output logic              overwrite
);

  logic             rst_sync_n;
  logic             store_en;
  logic             wr_step;
  logic             rd_step;
  logic             clear;
  logic             rd_capture;
  logic             rd_sentinel;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  ring_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ring_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .flush       (flush),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .level       (level),
    .store_en    (store_en),
    .wr_step     (wr_step),
    .rd_step     (rd_step),
    .clear       (clear),
    .rd_capture  (rd_capture),
    .rd_sentinel (rd_sentinel),
    .overwrite   (overwrite)
  );

  ring_index #(
    .DEPTH (DEPTH)
  ) u_wr_index (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clear),
    .adv   (wr_step),
    .idx   (wr_idx)
  );

  ring_index #(
    .DEPTH (DEPTH)
  ) u_rd_index (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clear),
    .adv   (rd_step),
    .idx   (rd_idx)
  );

  ring_store #(
    .DEPTH    (DEPTH),
    .DATA_W   (DATA_W),
    .SENTINEL (RB_SENTINEL)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .store_en    (store_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_byte),
    .rd_capture  (rd_capture),
    .rd_sentinel (rd_sentinel),
    .rd_idx      (rd_idx),
    .rd_data     (rd_byte)
  );

  // R5: when full, both positions coincide.
  assert_full_aligned_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (level == CNT_W'(DEPTH)) |-> (wr_idx == rd_idx));

  // R10: a flush realigns both positions to slot zero.
  assert_flush_idx_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (wr_idx == '0 && rd_idx == '0));

  // R1: inputs are defined once out of reset.
  assert_inputs_known_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$isunknown({flush, wr_valid, rd_req}));

endmodule

// File: tb/test_ring_buffer_ovw.sv
module test_ring_buffer_ovw;

  localparam int DEPTH  = 256;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk;
  logic              rst_n;
  logic              flush;
  logic              wr_valid;
  logic [DATA_W-1:0] wr_byte;
  logic              rd_req;
  logic [DATA_W-1:0] rd_byte;
  logic [CNT_W-1:0]  level;
  logic              overwrite;

  int n_checks;
  int n_fails;
  bit done;

  logic [DATA_W-1:0] model_q [$];
  logic [DATA_W-1:0] exp_rd;

  ring_buffer_ovw #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) i_ring_buffer_ovw (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .rd_req    (rd_req),
    .rd_byte   (rd_byte),
    .level     (level),
    .overwrite (overwrite)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
    n_checks++;
    if (actual !== expected) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  // One clock of stimulus, model update, then check at the falling edge.
  task automatic cycle(input string tag, input logic wv, input logic [7:0] wd,
                       input logic rr, input logic fl);
    logic exp_ovw;
    wr_valid = wv;
    wr_byte  = wd;
    rd_req   = rr;
    flush    = fl;
    exp_ovw  = 1'b0;
    if (fl) begin
      model_q.delete();
    end else begin
      if (rr) begin
        if (model_q.size() == 0) exp_rd = 8'hFF;
        else exp_rd = model_q.pop_front();
      end
      if (wv) begin
        if (model_q.size() == DEPTH) begin
          void'(model_q.pop_front());
          exp_ovw = 1'b1;
        end
        model_q.push_back(wd);
      end
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    rd_req   = 1'b0;
    flush    = 1'b0;
    check(tag, "level", 32'(level), 32'(model_q.size()));
    check(tag, "rd_byte", 32'(rd_byte), 32'(exp_rd));
    check(tag, "overwrite", 32'(overwrite), 32'(exp_ovw));
  endtask

  task automatic t_reset();
    check("R1", "level", 32'(level), 0);
    check("R1", "rd_byte", 32'(rd_byte), 32'hFF);
    check("R1", "overwrite", 32'(overwrite), 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 5; i++) cycle("R2", 1'b1, 8'(8'h10 + i), 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) cycle("R3", 1'b0, 8'h00, 1'b1, 1'b0);
    cycle("R12", 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_empty_read();
    cycle("R4", 1'b0, 8'h00, 1'b1, 1'b0);
    cycle("R4", 1'b0, 8'h00, 1'b1, 1'b0);
    cycle("R4", 1'b1, 8'h5A, 1'b0, 1'b0);
    cycle("R4", 1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_overwrite();
    for (int i = 0; i < DEPTH; i++) cycle("R2", 1'b1, 8'(i), 1'b0, 1'b0);
    cycle("R5", 1'b1, 8'hA1, 1'b0, 1'b0);
    cycle("R6", 1'b1, 8'hA2, 1'b0, 1'b0);
    cycle("R6", 1'b0, 8'h00, 1'b0, 1'b0);
    cycle("R8", 1'b1, 8'hB0, 1'b1, 1'b0);
    cycle("R5", 1'b0, 8'h00, 1'b1, 1'b0);
    cycle("R7", 1'b1, 8'hC3, 1'b1, 1'b0);
    cycle("R7", 1'b1, 8'hC4, 1'b1, 1'b0);
  endtask

  task automatic t_flush();
    cycle("R10", 1'b1, 8'hEE, 1'b1, 1'b1);
    cycle("R10", 1'b0, 8'h00, 1'b1, 1'b0);
    cycle("R9", 1'b1, 8'h77, 1'b1, 1'b0);
    cycle("R9", 1'b0, 8'h00, 1'b1, 1'b0);
    cycle("R10", 1'b1, 8'h01, 1'b0, 1'b0);
    cycle("R10", 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 3 * DEPTH + 7; i++) begin
      cycle("R11", 1'b1, 8'(i * 7 + 3), (i % 3) != 0, 1'b0);
    end
    while (model_q.size() != 0) cycle("R11", 1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    exp_rd   = 8'hFF;
    rst_n    = 1'b0;
    flush    = 1'b0;
    wr_valid = 1'b0;
    wr_byte  = '0;
    rd_req   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_drain();
    t_empty_read();
    t_overwrite();
    t_flush();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule